// File: doc/BRIEF.md
# Bus I/O Read-Modify-Write Sequencer

This block turns one processor I/O command into one or two bus cycles and a single response. A command carries an opcode, an effective address, an accumulator value and an alternate-mode flag. The sequencer can read or write a word or a byte. It can test a read value against the accumulator and report a skip. It can also set or clear bits by reading the target and then writing the changed value back. Byte commands select a lane from the low address bit. The bus always returns full words, so the byte is extracted inside the block.

Commands enter on a valid/ready pair. `cmd_ready` is high only while the sequencer is idle. A command is taken on the rising edge where `cmd_valid` and `cmd_ready` are both high. Bus requests use the same rule. A request holds its address, kind and data unchanged until the target returns `bus_ready`. On that same edge the target presents `bus_rdata` and `bus_err`. The response is held in `rsp_*` until the consumer raises `rsp_ready`. No new command is taken until then, so back-pressure on the response stalls the command side.

In alternate mode the test and bit opcodes stop being tests and read-modify-writes. They become plain transfers, and a fixed adapter number is ORed into the address above bit `ADP_SHIFT`.

Top module: `io_rmw_seq`

## Requirements
- R1: `cmd_ready` is 1 exactly when the sequencer is idle. While idle, neither `bus_valid` nor `rsp_valid` is high. `bus_valid` and `rsp_valid` are never high together. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a rising edge.
- R2: Once `bus_valid` is raised, `bus_addr`, `bus_kind` and `bus_wdata` stay unchanged until a cycle with `bus_ready` high. The bus kind codes are: 0 = read, 1 = word write, 2 = byte write.
- R3: Once `rsp_valid` is raised, `rsp_data`, `rsp_skip` and `rsp_err` stay unchanged until a cycle with `rsp_ready` high.
- R4: Opcode field `cmd_op[2:0]` is 3 for a write, and `cmd_op[3]` = 0 selects word size. A word write issues one cycle of kind 1 to `cmd_addr`, with `bus_wdata` set to `cmd_acc[15:0]`. `rsp_data` returns the written value.
- R5: A byte write (`cmd_op` = 4'hB) issues kind 2 to the unmodified `cmd_addr`. `bus_wdata[7:0]` is `cmd_acc[7:0]` and the upper bits are 0.
- R6: A read has `cmd_op[2:0]` = 2; `cmd_op` = 4'hA is the byte read. A byte read puts `cmd_addr` with bit 0 cleared on the bus. If `cmd_addr[0]` is 1 it returns `bus_rdata[15:8]`, otherwise `bus_rdata[7:0]`, zero-extended in `rsp_data`. A word read returns `bus_rdata`.
- R7: Test codes are 0 (skip if zero) and 1 (skip if nonzero), with `cmd_op[3]` selecting byte size. A test reads the target like R6 and returns the value in `rsp_data`. Code 0 sets `rsp_skip` when `cmd_acc` AND the value is 0. Code 1 sets it when that AND is nonzero.
- R8: Code 4 is bit-set and code 5 is bit-clear. For the word forms the sequencer reads `cmd_addr`, then word-writes the same address. The written value is `rdata | cmd_acc[15:0]` for set and `rdata & ~cmd_acc[15:0]` for clear.
- R9: The byte forms of set and clear (4'hC, 4'hD) read the aligned word and extract the addressed byte. They apply the change with `cmd_acc[7:0]` and then byte-write the result in bits 7:0 to the original `cmd_addr`.
- R10: With `cmd_alt` = 1, the opcodes change as follows (byte size is kept). Code 0 becomes a read of `cmd_addr | (3 << ADP_SHIFT)` and code 1 a read of `cmd_addr | (1 << ADP_SHIFT)`. Both return the value with `rsp_skip` = 0. Code 4 becomes a plain write of the accumulator to `cmd_addr | (3 << ADP_SHIFT)` and code 5 the same to `cmd_addr | (1 << ADP_SHIFT)`. Codes 2 and 3 are unchanged.
- R11: If `bus_err` is high in a `bus_ready` cycle, the sequence ends. No further bus request is made, so a bit-set or bit-clear does no write-back. The response has `rsp_err` = 1, `rsp_skip` = 0 and `rsp_data` = 0.
- R12: Codes 6 and 7 in `cmd_op[2:0]` are unused. They produce no bus cycle and respond with `rsp_err` = 1 and `rsp_data` = 0.
- R13: During and right after reset, `cmd_ready` = 1, `bus_valid` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 4 | Bit 3 = byte size, bits 2:0 = operation code |
| cmd_addr | input | ADDR_W (22) | Effective I/O address |
| cmd_acc | input | ACC_W (36) | Accumulator: mask, write value or test operand |
| cmd_alt | input | 1 | Alternate opcode mode |
| bus_valid | output | 1 | Bus request active |
| bus_ready | input | 1 | Target completes the request this cycle |
| bus_addr | output | ADDR_W (22) | Bus address |
| bus_kind | output | 2 | 0 read, 1 word write, 2 byte write |
| bus_wdata | output | BUS_W (16) | Write data, byte in bits 7:0 for byte writes |
| bus_rdata | input | BUS_W (16) | Read data, valid with bus_ready |
| bus_err | input | 1 | Target error, valid with bus_ready |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | ACC_W (36) | Value read, or value written |
| rsp_skip | output | 1 | Test result |
| rsp_err | output | 1 | Sequence aborted or opcode unused |

## Verification
Some properties are checked on every cycle. The handshake rules (held bus requests, held responses, idle exclusivity) are checked throughout. So are the zero upper lane on byte writes, the absence of any bus request after an erroring completion, and the clean zero response on error. Other behaviour only shows up in the bench's scenarios, because it depends on the command that started the sequence. This covers the arithmetic of set and clear, lane extraction, the aligned address on byte reads, the original address on byte write-back, skip polarity, and the alternate-mode address tags. The bench predicts the exact bus cycles and the response for each command and compares them while the bus and the response side both stall.

// File: rtl/io_rmw_pkg.sv
package io_rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE,
    ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    FN_RD,
    FN_WR,
    FN_TZ,
    FN_TNZ,
    FN_SET,
    FN_CLR
  } fn_e;

  localparam logic [1:0] BK_READ = 2'd0;
  localparam logic [1:0] BK_WORD = 2'd1;
  localparam logic [1:0] BK_BYTE = 2'd2;

  localparam logic [2:0] OPC_TZ  = 3'd0;
  localparam logic [2:0] OPC_TNZ = 3'd1;
  localparam logic [2:0] OPC_RD  = 3'd2;
  localparam logic [2:0] OPC_WR  = 3'd3;
  localparam logic [2:0] OPC_SET = 3'd4;
  localparam logic [2:0] OPC_CLR = 3'd5;

  typedef struct packed {
    logic legal;
    logic rd;
    logic wr;
    logic byte_op;
    fn_e  fn;
  } op_dec_t;

endpackage

// File: rtl/io_rmw_decode.sv
module io_rmw_decode
  import io_rmw_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int ADP_SHIFT = 18,
  parameter int ADP_A     = 3,
  parameter int ADP_B     = 1
) (
  input  logic [3:0]        op,
  input  logic              alt,
  input  logic [ADDR_W-1:0] addr,
  output op_dec_t           dec,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam logic [ADDR_W-1:0] TAG_A = ADDR_W'(ADP_A) << ADP_SHIFT;
  localparam logic [ADDR_W-1:0] TAG_B = ADDR_W'(ADP_B) << ADP_SHIFT;

  always_comb begin
    dec         = '0;
    dec.fn      = FN_RD;
    dec.byte_op = op[3];
    dec.legal   = 1'b1;
    eff_addr    = addr;
    case (op[2:0])
      OPC_TZ: begin
        dec.rd = 1'b1;
        if (alt) eff_addr = addr | TAG_A;
        else     dec.fn   = FN_TZ;
      end
      OPC_TNZ: begin
        dec.rd = 1'b1;
        if (alt) eff_addr = addr | TAG_B;
        else     dec.fn   = FN_TNZ;
      end
      OPC_RD: dec.rd = 1'b1;
      OPC_WR: begin
        dec.wr = 1'b1;
        dec.fn = FN_WR;
      end
      OPC_SET: begin
        dec.wr = 1'b1;
        if (alt) begin
          dec.fn   = FN_WR;
          eff_addr = addr | TAG_A;
        end else begin
          dec.rd = 1'b1;
          dec.fn = FN_SET;
        end
      end
      OPC_CLR: begin
        dec.wr = 1'b1;
        if (alt) begin
          dec.fn   = FN_WR;
          eff_addr = addr | TAG_B;
        end else begin
          dec.rd = 1'b1;
          dec.fn = FN_CLR;
        end
      end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/io_rmw_alu.sv
module io_rmw_alu
  import io_rmw_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ACC_W  = 36,
  parameter int LANE_W = 8,
  parameter int SEL_W  = 1
) (
  input  logic [BUS_W-1:0] rd_word,
  input  logic [ACC_W-1:0] acc,
  input  logic [SEL_W-1:0] lane,
  input  fn_e              fn,
  input  logic             byte_op,
  output logic [BUS_W-1:0] wdata,
  output logic [ACC_W-1:0] result,
  output logic             skip
);
  localparam int LANES = BUS_W / LANE_W;

  logic [LANE_W-1:0] lane_v [LANES];
  logic [BUS_W-1:0]  operand;
  logic [BUS_W-1:0]  mask;
  logic [BUS_W-1:0]  modv;
  logic              hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_v[g] = rd_word[g*LANE_W +: LANE_W];
  end

  always_comb begin
    operand = byte_op ? BUS_W'(lane_v[lane]) : rd_word;
    mask    = byte_op ? BUS_W'(acc[LANE_W-1:0]) : acc[BUS_W-1:0];
    case (fn)
      FN_SET:  modv = operand | mask;
      FN_CLR:  modv = operand & ~mask;
      FN_WR:   modv = mask;
      default: modv = operand;
    endcase
    hit = |(acc & ACC_W'(operand));
    case (fn)
      FN_TZ:   skip = ~hit;
      FN_TNZ:  skip = hit;
      default: skip = 1'b0;
    endcase
    wdata  = modv;
    result = ACC_W'(modv);
  end
endmodule

// File: rtl/io_rmw_seq.sv
module io_rmw_seq
  import io_rmw_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int ACC_W     = 36,
  parameter int BUS_W     = 16,
  parameter int ADP_SHIFT = 18,
  parameter int ADP_A     = 3,
  parameter int ADP_B     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ACC_W-1:0]  cmd_acc,
  input  logic              cmd_alt,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_kind,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata,
  input  logic              bus_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ACC_W-1:0]  rsp_data,
  output logic              rsp_skip,
  output logic              rsp_err
);
  localparam int LANE_W = 8;
  localparam int LANES  = BUS_W / LANE_W;
  localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LANES - 1);

  seq_state_e        state_q;
  op_dec_t           dec_in, dec_q;
  logic [ADDR_W-1:0] eff_in, addr_q;
  logic [ACC_W-1:0]  acc_q, res_q;
  logic [BUS_W-1:0]  rd_q, wdata_q, alu_wdata;
  logic [ACC_W-1:0]  alu_res;
  logic              alu_skip, skip_q, err_q;

  io_rmw_decode #(
    .ADDR_W(ADDR_W), .ADP_SHIFT(ADP_SHIFT), .ADP_A(ADP_A), .ADP_B(ADP_B)
  ) u_dec (
    .op(cmd_op), .alt(cmd_alt), .addr(cmd_addr), .dec(dec_in), .eff_addr(eff_in)
  );

  io_rmw_alu #(
    .BUS_W(BUS_W), .ACC_W(ACC_W), .LANE_W(LANE_W), .SEL_W(SEL_W)
  ) u_alu (
    .rd_word(rd_q), .acc(acc_q), .lane(addr_q[SEL_W-1:0]), .fn(dec_q.fn),
    .byte_op(dec_q.byte_op), .wdata(alu_wdata), .result(alu_res), .skip(alu_skip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dec_q   <= '0;
      addr_q  <= '0;
      acc_q   <= '0;
      rd_q    <= '0;
      wdata_q <= '0;
      res_q   <= '0;
      skip_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          dec_q  <= dec_in;
          addr_q <= eff_in;
          acc_q  <= cmd_acc;
          rd_q   <= '0;
          res_q  <= '0;
          skip_q <= 1'b0;
          err_q  <= 1'b0;
          if (!dec_in.legal) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (dec_in.rd) begin
            state_q <= ST_READ;
          end else begin
            state_q <= ST_MODIFY;
          end
        end
        ST_READ: if (bus_ready) begin
          if (bus_err) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            rd_q    <= bus_rdata;
            state_q <= ST_MODIFY;
          end
        end
        ST_MODIFY: begin
          res_q   <= alu_res;
          skip_q  <= alu_skip;
          wdata_q <= alu_wdata;
          state_q <= dec_q.wr ? ST_WRITE : ST_DONE;
        end
        ST_WRITE: if (bus_ready) begin
          if (bus_err) begin
            err_q  <= 1'b1;
            res_q  <= '0;
            skip_q <= 1'b0;
          end
          state_q <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready = (state_q == ST_IDLE);
    bus_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
    rsp_valid = (state_q == ST_DONE);
    if (state_q == ST_READ) begin
      bus_kind  = BK_READ;
      bus_addr  = dec_q.byte_op ? (addr_q & ALIGN_MASK) : addr_q;
      bus_wdata = '0;
    end else begin
      bus_kind  = dec_q.byte_op ? BK_BYTE : BK_WORD;
      bus_addr  = addr_q;
      bus_wdata = (state_q == ST_WRITE) ? wdata_q : '0;
    end
    rsp_data = res_q;
    rsp_skip = skip_q;
    rsp_err  = err_q;
  end
endmodule

// File: rtl/io_rmw_seq_chk.sv
module io_rmw_seq_chk #(
  parameter int ADDR_W = 22,
  parameter int ACC_W  = 36,
  parameter int BUS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_err,
  input logic [1:0]        bus_kind,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ACC_W-1:0]  rsp_data,
  input logic              rsp_skip,
  input logic              rsp_err
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_valid && !rsp_valid));

  p_one_side_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && rsp_valid));

  p_bus_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_kind) && $stable(bus_wdata)));

  p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_kind != 2'd3));

  p_rsp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                   $stable(rsp_skip) && $stable(rsp_err)));

  p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_kind == 2'd2) |-> (bus_wdata[BUS_W-1:8] == '0));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_err) |=> !bus_valid);

  p_err_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!rsp_skip && rsp_data == '0));
endmodule

bind io_rmw_seq io_rmw_seq_chk #(
  .ADDR_W(ADDR_W), .ACC_W(ACC_W), .BUS_W(BUS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_err(bus_err), .bus_kind(bus_kind),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_skip(rsp_skip),
  .rsp_err(rsp_err)
);

// File: tb/io_rmw_seq_bench.sv
`timescale 1ns/1ps
module io_rmw_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [21:0] cmd_addr = '0;
  logic [35:0] cmd_acc = '0;
  logic        cmd_alt = 1'b0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [21:0] bus_addr;
  logic [1:0]  bus_kind;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = 16'hDEAD;
  logic        bus_err = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [35:0] rsp_data;
  logic        rsp_skip;
  logic        rsp_err;

  int total = 0;
  int bad = 0;
  bit summary_done = 0;

  typedef struct {
    logic [1:0]  kind;
    logic [21:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    bit          err;
  } bop_t;
  bop_t q[$];

  always #2.5 clk = ~clk;

  io_rmw_seq u_io_rmw_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_acc(cmd_acc), .cmd_alt(cmd_alt),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_kind(bus_kind), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_skip(rsp_skip), .rsp_err(rsp_err)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // mode: 0 read, 1 write, 2 test-zero, 3 test-nonzero, 4 set, 5 clear, -1 unused
  task automatic run(string req, logic [3:0] op, logic [21:0] addr, logic [35:0] acc,
                     bit alt, logic [15:0] rdata, bit rerr, bit werr, int blat, int rlat);
    logic [21:0] ea;
    logic [21:0] tag_a;
    logic [21:0] tag_b;
    logic [15:0] val;
    logic [15:0] mask;
    logic [15:0] wv;
    logic [35:0] exp_res;
    bit          exp_skip;
    bit          exp_err;
    bit          byt;
    bit          fin;
    int          mode;
    int          wait_b;
    int          wait_r;
    bop_t        b;
    ea = addr;
    tag_a = 22'(3) << 18;
    tag_b = 22'(1) << 18;
    byt = op[3];
    case (op[2:0])
      3'd0: if (alt) begin mode = 0; ea = addr | tag_a; end else mode = 2;
      3'd1: if (alt) begin mode = 0; ea = addr | tag_b; end else mode = 3;
      3'd2: mode = 0;
      3'd3: mode = 1;
      3'd4: if (alt) begin mode = 1; ea = addr | tag_a; end else mode = 4;
      3'd5: if (alt) begin mode = 1; ea = addr | tag_b; end else mode = 5;
      default: mode = -1;
    endcase
    val = byt ? (ea[0] ? {8'h00, rdata[15:8]} : {8'h00, rdata[7:0]}) : rdata;
    mask = byt ? {8'h00, acc[7:0]} : acc[15:0];
    case (mode)
      4: wv = val | mask;
      5: wv = val & ~mask;
      default: wv = mask;
    endcase
    exp_err = 0; exp_skip = 0; exp_res = '0;
    q.delete();
    if (mode == -1) begin
      exp_err = 1;
    end else begin
      if (mode != 1) begin
        b.kind = 2'd0; b.addr = byt ? {ea[21:1], 1'b0} : ea;
        b.wdata = '0; b.rdata = rdata; b.err = rerr;
        q.push_back(b);
      end
      if (mode != 1 && rerr) begin
        exp_err = 1;
      end else if (mode == 1 || mode == 4 || mode == 5) begin
        b.kind = byt ? 2'd2 : 2'd1; b.addr = ea; b.wdata = wv; b.rdata = 16'h0; b.err = werr;
        q.push_back(b);
        if (werr) exp_err = 1;
        else exp_res = 36'(wv);
      end else begin
        exp_res = 36'(val);
        if (mode == 2) exp_skip = ((acc & 36'(val)) == 0);
        if (mode == 3) exp_skip = ((acc & 36'(val)) != 0);
      end
    end

    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "cmd_ready idle", cmd_ready, 1);
    cmd_valid = 1; cmd_op = op; cmd_addr = addr; cmd_acc = acc; cmd_alt = alt;
    @(negedge clk);
    cmd_valid = 0;
    fin = 0; wait_b = 0; wait_r = 0;
    for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
      bus_ready = 0; bus_rdata = 16'hDEAD; bus_err = 0; rsp_ready = 0;
      if (cmd_ready) begin
        check(0, "R1", "cmd_ready while busy", 1, 0);
        fin = 1;
      end
      if (bus_valid) begin
        if (q.size() == 0) begin
          check(0, req, "unexpected bus request addr", bus_addr, 0);
          bus_ready = 1;
        end else if (wait_b < blat) begin
          wait_b++;
        end else begin
          check(bus_kind == q[0].kind, req, "bus kind", bus_kind, q[0].kind);
          check(bus_addr == q[0].addr, req, "bus addr", bus_addr, q[0].addr);
          if (q[0].kind != 2'd0)
            check(bus_wdata == q[0].wdata, req, "bus wdata", bus_wdata, q[0].wdata);
          bus_ready = 1; bus_rdata = q[0].rdata; bus_err = q[0].err;
          void'(q.pop_front());
          wait_b = 0;
        end
      end
      if (rsp_valid && !fin) begin
        if (wait_r < rlat) begin
          wait_r++;
        end else begin
          check(q.size() == 0, req, "bus cycles missing", q.size(), 0);
          check(rsp_err == exp_err, req, "rsp_err", rsp_err, exp_err);
          check(rsp_skip == exp_skip, req, "rsp_skip", rsp_skip, exp_skip);
          check(rsp_data == exp_res, req, "rsp_data", rsp_data, exp_res);
          rsp_ready = 1;
          fin = 1;
        end
      end
      @(negedge clk);
    end
    bus_ready = 0; rsp_ready = 0; bus_err = 0;
    if (!fin) check(0, req, "watchdog: no response", 0, 1);
  endtask

  initial begin
    #(200000 * 5);
    check(0, "ALL", "global watchdog expired", 0, 1);
    if (!summary_done) begin
      summary_done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready == 1 && bus_valid == 0 && rsp_valid == 0, "R13", "in-reset state",
          {cmd_ready, bus_valid, rsp_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready == 1 && bus_valid == 0 && rsp_valid == 0, "R13", "post-reset state",
          {cmd_ready, bus_valid, rsp_valid}, 3'b100);

    // R6 word and byte reads
    run("R6", 4'h2, 22'h01234, 36'h0, 0, 16'hBEEF, 0, 0, 0, 0);
    run("R6", 4'hA, 22'h00101, 36'h0, 0, 16'hC3A5, 0, 0, 2, 0);
    run("R6", 4'hA, 22'h00100, 36'h0, 0, 16'hC3A5, 0, 0, 0, 1);
    // R4 and R5 writes
    run("R4", 4'h3, 22'h02222, 36'h9_1234_ABCD, 0, 16'h0, 0, 0, 1, 0);
    run("R5", 4'hB, 22'h03331, 36'h0_0000_05A7, 0, 16'h0, 0, 0, 0, 0);
    // R7 tests
    run("R7", 4'h0, 22'h00010, 36'h0_0000_00F0, 0, 16'h0F0F, 0, 0, 0, 0);
    run("R7", 4'h1, 22'h00010, 36'h0_0000_00F0, 0, 16'h0F0F, 0, 0, 0, 0);
    run("R7", 4'h1, 22'h00012, 36'h8_0000_0001, 0, 16'h0001, 0, 0, 3, 2);
    run("R7", 4'h8, 22'h00013, 36'h0_0000_0001, 0, 16'h0201, 0, 0, 0, 0);
    run("R7", 4'h9, 22'h00013, 36'h0_0000_0002, 0, 16'h0201, 0, 0, 0, 0);
    // R8 word set / clear
    run("R8", 4'h4, 22'h00400, 36'h0_0000_0F0F, 0, 16'h00F0, 0, 0, 1, 0);
    run("R8", 4'h5, 22'h00402, 36'h0_0000_00FF, 0, 16'hFFFF, 0, 0, 0, 2);
    // R9 byte set / clear
    run("R9", 4'hC, 22'h00501, 36'h0_0000_0005, 0, 16'h1200, 0, 0, 2, 0);
    run("R9", 4'hD, 22'h00500, 36'h0_0000_000F, 0, 16'h12FF, 0, 0, 0, 0);
    // R10 alternate mode
    run("R10", 4'h0, 22'h00020, 36'h0_0000_0000, 1, 16'h4321, 0, 0, 0, 0);
    run("R10", 4'h1, 22'h00020, 36'h0_0000_FFFF, 1, 16'h4321, 0, 0, 0, 0);
    run("R10", 4'h4, 22'h00030, 36'h0_0001_7777, 1, 16'h0, 0, 0, 0, 0);
    run("R10", 4'hD, 22'h00031, 36'h0_0000_0196, 1, 16'h0, 0, 0, 0, 0);
    run("R10", 4'h9, 22'h00041, 36'h0, 1, 16'hAB12, 0, 0, 0, 0);
    run("R10", 4'h2, 22'h00044, 36'h0, 1, 16'h5555, 0, 0, 0, 0);
    // R11 bus errors
    run("R11", 4'h4, 22'h00600, 36'h0_0000_00FF, 0, 16'h1234, 1, 0, 0, 0);
    run("R11", 4'h3, 22'h00602, 36'h0_0000_1111, 0, 16'h0, 0, 1, 1, 1);
    run("R11", 4'h0, 22'h00604, 36'h0, 0, 16'h0, 1, 0, 0, 0);
    // R12 unused codes
    run("R12", 4'h6, 22'h00700, 36'h0_0000_FFFF, 0, 16'h0, 0, 0, 0, 0);
    run("R12", 4'hF, 22'h00701, 36'h0_0000_FFFF, 1, 16'h0, 0, 0, 0, 1);
    // R2 and R3 under long stalls
    run("R2", 4'h5, 22'h00800, 36'h0_0000_0F00, 0, 16'hFFFF, 0, 0, 5, 0);
    run("R3", 4'h2, 22'h00802, 36'h0, 0, 16'h7E7E, 0, 0, 0, 6);

    if (!summary_done) begin
      summary_done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule